// File: doc/BRIEF.md
# FSK NCO Modulator with Transition Shaping

This block produces the transmit sample stream of a binary FSK signal on a low intermediate frequency. A 17-bit phase accumulator advances once per sample clock by a frequency word. Its top four bits address a 16-entry sine table, and the 4-bit result goes to an external DAC. The frequency word is the programmed centre word plus or minus the programmed peak deviation. All words are in steps of 62.5 Hz, so 2^17 steps span the 8.192 MHz sample rate. A typical setting is 40128 for the centre (2.508 MHz) and 521 for the deviation (about 32.6 kHz). The wanted 10.7 MHz product is then the image of the centre tone about the sample rate.

The symbol changes when a bit strobe presents a bit that differs from the current symbol. The frequency does not jump straight to the new tone. A shaper walks it through four programmable intermediate offsets that belong to the target symbol, holding each one for a programmable number of sample clocks, and then settles on the full deviation. The output runs only while the power gate is high and the external frame count has reached a programmable turn-on value. Otherwise the output sits at mid-scale and the phase is held at zero.

Top module: `fsk_nco_mod_top`

## Requirements
- R1: After reset, dac_out is 8, the current symbol is 0 and no shaping is in progress. The configuration resets to: centre 40128, deviation 521, all eight intermediate offsets 0, dwell 4, turn-on 0.
- R2: On each clock edge while enabled, dac_out becomes T[p>>13], where p is the 17-bit phase held before that edge. T for index 0..15 is 8,11,13,14,15,14,13,11,8,5,3,2,1,2,3,5. At the same edge the phase becomes (p + frequency word) modulo 131072.
- R3: With no shaping in progress, the frequency word is (centre + deviation) modulo 131072 for symbol 1 and (centre − deviation) modulo 131072 for symbol 0. Centre and deviation are unsigned 16-bit values.
- R4: A strobe whose bit differs from the current symbol makes that bit the symbol and starts shaping at step 0. Steps 0..3 each last dwell clocks. During step k the frequency word is centre plus the signed 16-bit offset k of the target symbol: the rising set for symbol 1 and the falling set for symbol 0. After step 3, R3 applies again.
- R5: A strobe whose bit equals the current symbol is ignored. A shaping run in progress continues and an idle tone stays unchanged.
- R6: A strobe with a differing bit that arrives during shaping restarts shaping at step 0 toward the new symbol. This includes a strobe in the last clock of step 3.
- R7: A dwell value of 0 behaves as a dwell of 1.
- R8: The modulator is enabled when pwr_en is 1 and frame_cnt ≥ the turn-on value (unsigned). While it is disabled, dac_out is 8 and the phase is 0, so every enable starts from phase 0. Symbol tracking and shaping go on while the modulator is disabled.
- R9: A write with cfg_we=1 takes effect from the next clock. The address map is: 0 centre, 1 deviation, 2..5 rising offsets for steps 0..3, 6..9 falling offsets for steps 0..3, 10 dwell (low 8 bits), 11 turn-on (low 8 bits). Writes to addresses 12..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| tx_bit | input | 1 | Bit to transmit, sampled with bit_stb |
| bit_stb | input | 1 | One-clock bit strobe |
| pwr_en | input | 1 | Modulator power gate |
| frame_cnt | input | 8 | Transmit frame position, compared with turn-on |
| dac_out | output | 4 | Offset-binary sample for the DAC |

## Verification
Two functions can fall in the same cycle. The first pair is the shaper's final step ending and a new strobe arriving. The second pair is a configuration write and an active shaping run that reads the written word. The bench provokes the first by sweeping the gap between strobes across the exact length of a shaping run (four times the dwell) and provokes the second by rewriting dwell and centre while a run is mid-way. A behavioural model in the bench tracks phase, symbol, step and dwell count with plain integers, and the output is judged against it on every clock. A wrong choice between restart and settle, or a write applied a cycle early, shows up as a diverging sample stream.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

    localparam int unsigned LUT_AW = 4;
    localparam int unsigned DAC_W  = 4;
    localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1 << (DAC_W - 1));

    localparam int unsigned ADR_CENTRE = 0;
    localparam int unsigned ADR_DEV    = 1;
    localparam int unsigned ADR_RISE   = 2;

    function automatic logic [2:0] quarter_mag(input logic [2:0] pos);
        logic [2:0] mag;
        case (pos)
            3'd0:    mag = 3'd0;
            3'd1:    mag = 3'd3;
            3'd2:    mag = 3'd5;
            3'd3:    mag = 3'd6;
            default: mag = 3'd7;
        endcase
        return mag;
    endfunction

    function automatic logic [DAC_W-1:0] sine_lut(input logic [LUT_AW-1:0] idx);
        logic [2:0] pos;
        logic [2:0] mag;
        if (idx[2]) pos = 3'd4 - {1'b0, idx[1:0]};
        else        pos = {1'b0, idx[1:0]};
        mag = quarter_mag(pos);
        if (idx[3]) return DAC_MID - DAC_W'(mag);
        else        return DAC_MID + DAC_W'(mag);
    endfunction

endpackage

// File: rtl/fsk_cfg_regs.sv
module fsk_cfg_regs
    import fsk_mod_pkg::*;
#(
    parameter int unsigned FW_W    = 16,
    parameter int unsigned DWELL_W = 8,
    parameter int unsigned FRAME_W = 8,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned NSTEP   = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [FW_W-1:0]                wdata_i,
    output logic [FW_W-1:0]                centre_o,
    output logic [FW_W-1:0]                dev_o,
    output logic [NSTEP-1:0][FW_W-1:0]     rise_o,
    output logic [NSTEP-1:0][FW_W-1:0]     fall_o,
    output logic [DWELL_W-1:0]             dwell_o,
    output logic [FRAME_W-1:0]             ton_o
);

    localparam int unsigned ADR_FALL  = ADR_RISE + NSTEP;
    localparam int unsigned ADR_DWELL = ADR_FALL + NSTEP;
    localparam int unsigned ADR_TON   = ADR_DWELL + 1;
    localparam logic [FW_W-1:0] CENTRE_RST = FW_W'(40128);
    localparam logic [FW_W-1:0] DEV_RST    = FW_W'(521);
    localparam logic [DWELL_W-1:0] DWELL_RST = DWELL_W'(4);

    typedef struct packed {
        logic [FW_W-1:0]            centre;
        logic [FW_W-1:0]            dev;
        logic [NSTEP-1:0][FW_W-1:0] rise;
        logic [NSTEP-1:0][FW_W-1:0] fall;
        logic [DWELL_W-1:0]         dwell;
        logic [FRAME_W-1:0]         ton;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            if (addr_i == ADDR_W'(ADR_CENTRE)) cfg_d.centre = wdata_i;
            if (addr_i == ADDR_W'(ADR_DEV))    cfg_d.dev    = wdata_i;
            for (int k = 0; k < int'(NSTEP); k++) begin
                if (addr_i == ADDR_W'(ADR_RISE + k)) cfg_d.rise[k] = wdata_i;
                if (addr_i == ADDR_W'(ADR_FALL + k)) cfg_d.fall[k] = wdata_i;
            end
            if (addr_i == ADDR_W'(ADR_DWELL)) cfg_d.dwell = wdata_i[DWELL_W-1:0];
            if (addr_i == ADDR_W'(ADR_TON))   cfg_d.ton   = wdata_i[FRAME_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q        <= '0;
            cfg_q.centre <= CENTRE_RST;
            cfg_q.dev    <= DEV_RST;
            cfg_q.dwell  <= DWELL_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign centre_o = cfg_q.centre;
    assign dev_o    = cfg_q.dev;
    assign rise_o   = cfg_q.rise;
    assign fall_o   = cfg_q.fall;
    assign dwell_o  = cfg_q.dwell;
    assign ton_o    = cfg_q.ton;

    // R9: a centre write is visible one clock later
    p_centre_write_r9: assert property (@(posedge clk) disable iff (rst)
        (we_i && addr_i == ADDR_W'(ADR_CENTRE)) |=> (centre_o == $past(wdata_i)));

    // R9: with no write enable the configuration holds
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> ($stable(centre_o) && $stable(dev_o) && $stable(dwell_o) && $stable(ton_o)));

endmodule

// File: rtl/fsk_shaper.sv
module fsk_shaper #(
    parameter int unsigned FW_W    = 16,
    parameter int unsigned ACC_W   = 17,
    parameter int unsigned DWELL_W = 8,
    parameter int unsigned NSTEP   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stb_i,
    input  logic                       bit_i,
    input  logic [FW_W-1:0]            centre_i,
    input  logic [FW_W-1:0]            dev_i,
    input  logic [NSTEP-1:0][FW_W-1:0] rise_i,
    input  logic [NSTEP-1:0][FW_W-1:0] fall_i,
    input  logic [DWELL_W-1:0]         dwell_i,
    output logic [ACC_W-1:0]           fw_o
);

    localparam int unsigned SW  = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam int unsigned PAD = ACC_W - FW_W;

    typedef struct packed {
        logic               sym;
        logic               shaping;
        logic [SW-1:0]      step;
        logic [DWELL_W-1:0] cnt;
    } shp_t;

    shp_t s_d, s_q;

    logic [DWELL_W-1:0] dwell_eff;
    logic               last_cnt;
    logic               last_step;
    logic               flip;
    logic [FW_W-1:0]    step_off;
    logic [ACC_W-1:0]   dev_ext;
    logic [ACC_W-1:0]   off_ext;

    always_comb begin
        dwell_eff = (dwell_i == '0) ? DWELL_W'(1) : dwell_i;
        last_cnt  = (s_q.cnt == dwell_eff - DWELL_W'(1));
        last_step = (s_q.step == SW'(NSTEP - 1));
        flip      = stb_i && (bit_i != s_q.sym);

        step_off = s_q.sym ? rise_i[s_q.step] : fall_i[s_q.step];
        dev_ext  = {{PAD{1'b0}}, dev_i};
        if (s_q.shaping)   off_ext = {{PAD{step_off[FW_W-1]}}, step_off};
        else if (s_q.sym)  off_ext = dev_ext;
        else               off_ext = ACC_W'(0) - dev_ext;
        fw_o = {{PAD{1'b0}}, centre_i} + off_ext;

        s_d = s_q;
        if (flip) begin
            s_d.sym     = bit_i;
            s_d.shaping = 1'b1;
            s_d.step    = '0;
            s_d.cnt     = '0;
        end else if (s_q.shaping) begin
            if (last_cnt) begin
                s_d.cnt = '0;
                if (last_step) s_d.shaping = 1'b0;
                else           s_d.step    = s_q.step + SW'(1);
            end else begin
                s_d.cnt = s_q.cnt + DWELL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R5: the symbol moves only on a strobe
    p_sym_needs_stb_r5: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(s_q.sym));

    // R4: every shaping run begins at step 0
    p_start_step0_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.shaping) |-> (s_q.step == '0 && s_q.cnt == '0));

    // R6: a differing strobe restarts the run, even on its last clock
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (stb_i && bit_i != s_q.sym) |=> (s_q.shaping && s_q.step == '0 && s_q.sym == $past(bit_i)));

    // R4: the step index holds inside a dwell period
    p_step_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (s_q.shaping && !stb_i && !last_cnt) |=> (s_q.step == $past(s_q.step)));

    // R4: a run ends only after its final step
    p_end_last_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(s_q.shaping) |-> ($past(s_q.step) == SW'(NSTEP - 1)));

endmodule

// File: rtl/fsk_nco.sv
module fsk_nco
    import fsk_mod_pkg::*;
#(
    parameter int unsigned ACC_W = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [ACC_W-1:0]   inc_i,
    output logic [DAC_W-1:0]   sample_o
);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [DAC_W-1:0] sample;
    } nco_t;

    nco_t n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (en_i) begin
            n_d.sample = sine_lut(n_q.acc[ACC_W-1 -: LUT_AW]);
            n_d.acc    = n_q.acc + inc_i;
        end else begin
            n_d.sample = DAC_MID;
            n_d.acc    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q.acc    <= '0;
            n_q.sample <= DAC_MID;
        end else begin
            n_q <= n_d;
        end
    end

    assign sample_o = n_q.sample;

    // R8: a disabled modulator parks at mid-scale with zero phase
    p_off_mid_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (sample_o == DAC_MID && n_q.acc == '0));

    // R2: the phase advances by exactly the frequency word
    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (n_q.acc == $past(n_q.acc) + $past(inc_i)));

    // R8: the first sample after enabling is the zero-phase value
    p_first_mid_r8: assert property (@(posedge clk) disable iff (rst)
        (en_i && n_q.acc == '0) |=> (sample_o == DAC_MID));

endmodule

// File: rtl/fsk_nco_mod_top.sv
module fsk_nco_mod_top
    import fsk_mod_pkg::*;
#(
    parameter int unsigned FW_W    = 16,
    parameter int unsigned ACC_W   = 17,
    parameter int unsigned DWELL_W = 8,
    parameter int unsigned FRAME_W = 8,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned NSTEP   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [FW_W-1:0]    cfg_wdata,
    input  logic               tx_bit,
    input  logic               bit_stb,
    input  logic               pwr_en,
    input  logic [FRAME_W-1:0] frame_cnt,
    output logic [DAC_W-1:0]   dac_out
);

    logic [FW_W-1:0]            centre;
    logic [FW_W-1:0]            dev;
    logic [NSTEP-1:0][FW_W-1:0] rise;
    logic [NSTEP-1:0][FW_W-1:0] fall;
    logic [DWELL_W-1:0]         dwell;
    logic [FRAME_W-1:0]         ton;
    logic [ACC_W-1:0]           fw;
    logic                       mod_en;

    assign mod_en = pwr_en && (frame_cnt >= ton);

    fsk_cfg_regs #(
        .FW_W(FW_W), .DWELL_W(DWELL_W), .FRAME_W(FRAME_W),
        .ADDR_W(ADDR_W), .NSTEP(NSTEP)
    ) i_regs (
        .clk(clk), .rst(rst), .we_i(cfg_we), .addr_i(cfg_addr), .wdata_i(cfg_wdata),
        .centre_o(centre), .dev_o(dev), .rise_o(rise), .fall_o(fall),
        .dwell_o(dwell), .ton_o(ton)
    );

    fsk_shaper #(
        .FW_W(FW_W), .ACC_W(ACC_W), .DWELL_W(DWELL_W), .NSTEP(NSTEP)
    ) i_shaper (
        .clk(clk), .rst(rst), .stb_i(bit_stb), .bit_i(tx_bit),
        .centre_i(centre), .dev_i(dev), .rise_i(rise), .fall_i(fall),
        .dwell_i(dwell), .fw_o(fw)
    );

    fsk_nco #(
        .ACC_W(ACC_W)
    ) i_nco (
        .clk(clk), .rst(rst), .en_i(mod_en), .inc_i(fw), .sample_o(dac_out)
    );

    // R8: power gate low always yields mid-scale on the next clock
    p_gate_low_r8: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |=> (dac_out == DAC_MID));

endmodule

// File: tb/test_fsk_nco_mod_top.sv
module test_fsk_nco_mod_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        tx_bit;
    logic        bit_stb;
    logic        pwr_en;
    logic [7:0]  frame_cnt;
    logic [3:0]  dac_out;

    always #10 clk = ~clk;

    fsk_nco_mod_top i_fsk_nco_mod_top (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_bit(tx_bit), .bit_stb(bit_stb),
        .pwr_en(pwr_en), .frame_cnt(frame_cnt), .dac_out(dac_out)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // behavioural reference state
    int m_centre, m_dev, m_dwell, m_ton;
    int m_rise[4];
    int m_fall[4];
    int m_sym, m_shp, m_idx, m_cnt, m_acc, m_samp;

    function automatic int table_ref(int k);
        case (k)
            0: return 8;   1: return 11;  2: return 13;  3: return 14;
            4: return 15;  5: return 14;  6: return 13;  7: return 11;
            8: return 8;   9: return 5;   10: return 3;  11: return 2;
            12: return 1;  13: return 2;  14: return 3;  default: return 5;
        endcase
    endfunction

    function automatic int to_signed16(int v);
        return (v >= 32768) ? v - 65536 : v;
    endfunction

    task automatic check(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s at %0t: got %0d expected %0d", req, $time, got, exp);
        end
    endtask

    always @(posedge clk) begin
        int en_m, off, inc, dw;
        if (rst) begin
            m_centre = 40128; m_dev = 521; m_dwell = 4; m_ton = 0;
            for (int k = 0; k < 4; k++) begin m_rise[k] = 0; m_fall[k] = 0; end
            m_sym = 0; m_shp = 0; m_idx = 0; m_cnt = 0; m_acc = 0; m_samp = 8;
        end else begin
            en_m = (pwr_en && (int'(frame_cnt) >= m_ton)) ? 1 : 0;
            if (m_shp != 0) off = (m_sym != 0) ? to_signed16(m_rise[m_idx]) : to_signed16(m_fall[m_idx]);
            else            off = (m_sym != 0) ? m_dev : -m_dev;
            inc = (((m_centre + off) % 131072) + 131072) % 131072;
            if (en_m != 0) begin
                m_samp = table_ref(m_acc / 8192);
                m_acc  = (m_acc + inc) % 131072;
            end else begin
                m_samp = 8;
                m_acc  = 0;
            end
            dw = (m_dwell == 0) ? 1 : m_dwell;
            if (bit_stb && int'(tx_bit) != m_sym) begin
                m_sym = int'(tx_bit); m_shp = 1; m_idx = 0; m_cnt = 0;
            end else if (m_shp != 0) begin
                if (m_cnt == dw - 1) begin
                    m_cnt = 0;
                    if (m_idx == 3) m_shp = 0;
                    else            m_idx = m_idx + 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (cfg_we) begin
                case (int'(cfg_addr))
                    0: m_centre = int'(cfg_wdata);
                    1: m_dev    = int'(cfg_wdata);
                    2, 3, 4, 5: m_rise[int'(cfg_addr) - 2] = int'(cfg_wdata);
                    6, 7, 8, 9: m_fall[int'(cfg_addr) - 6] = int'(cfg_wdata);
                    10: m_dwell = int'(cfg_wdata) % 256;
                    11: m_ton   = int'(cfg_wdata) % 256;
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !rst && !done) check(cur_req, int'(dac_out), m_samp);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(int b);
        @(negedge clk);
        bit_stb = 1'b1; tx_bit = (b != 0);
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int b;
        int lfsr;
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        tx_bit = 1'b0; bit_stb = 1'b0; pwr_en = 1'b0; frame_cnt = '0;
        repeat (3) @(negedge clk);
        check("R1", int'(dac_out), 8);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R1: default configuration runs straight away once enabled
        cur_req = "R1"; pwr_en = 1'b1; idle(40); pwr_en = 1'b0;

        // R8: shaping continues while disabled, output parked
        cur_req = "R8";
        strobe(1); idle(5); strobe(0); idle(5);
        check("R8", int'(dac_out), 8);

        // R9: program the map, including an unmapped address
        cur_req = "R9";
        wr(0, 40128); wr(1, 521);
        wr(2, 65136); wr(3, 65336); wr(4, 200); wr(5, 400);
        wr(6, 400);   wr(7, 200);   wr(8, 65336); wr(9, 65136);
        wr(10, 3); wr(11, 5); wr(12, 1234); wr(15, 77);

        // R8: turn-on threshold not yet reached
        cur_req = "R8"; frame_cnt = 8'd2; pwr_en = 1'b1; idle(10);
        check("R8", int'(dac_out), 8);
        frame_cnt = 8'd5; idle(20);

        // R2 and R3: steady tone on symbol 0, then a plain sweep
        cur_req = "R3"; idle(30);
        cur_req = "R2"; wr(0, 8192); wr(1, 0); idle(20); wr(0, 40128); wr(1, 521);

        // R4: shaped transitions both ways
        cur_req = "R4";
        for (int i = 0; i < 6; i++) begin strobe(i % 2 == 0 ? 1 : 0); idle(20); end

        // R5: repeated bit is ignored, mid-run and idle
        cur_req = "R5";
        strobe(1); idle(3); strobe(1); idle(20); strobe(1); idle(10);

        // R6: restarts mid-run and on the last clock of the final step
        cur_req = "R6";
        strobe(0); idle(2); strobe(1); idle(4); strobe(0); idle(30);
        b = 1;
        for (int n = 8; n <= 12; n++) begin strobe(b); b = 1 - b; idle(n); end
        idle(20);

        // R9: writes landing during a run
        cur_req = "R9";
        strobe(b); b = 1 - b; wr(10, 2); wr(0, 50000); wr(3, 1000); idle(20);

        // R7: zero dwell
        cur_req = "R7"; wr(10, 0);
        for (int i = 0; i < 6; i++) begin strobe(b); b = 1 - b; idle(i); end
        idle(10);
        wr(10, 3);

        // R3: word wraps above and below the accumulator range
        cur_req = "R3";
        wr(0, 65535); wr(1, 30000); idle(30); strobe(1 - b); b = 1 - b; idle(30);
        wr(0, 100); idle(30); strobe(1 - b); b = 1 - b; idle(30);
        wr(0, 40128); wr(1, 521);

        // R4: long pseudo-random bit run
        cur_req = "R4"; lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
            strobe(lfsr & 1);
            idle((lfsr >> 3) % 16);
        end

        // R8: gating by frame position and power
        cur_req = "R8";
        frame_cnt = 8'd4; idle(5);
        check("R8", int'(dac_out), 8);
        frame_cnt = 8'd6; idle(20);
        pwr_en = 1'b0; idle(3);
        check("R8", int'(dac_out), 8);
        pwr_en = 1'b1; idle(20);

        finish_run();
    end

endmodule